// File: doc/BRIEF.md
# ECC Error Status and Injection Register

This block is the control and status register for the error-correction logic that protects three internal RAMs of a flash controller: the read FIFO RAM, the write FIFO RAM and the ECC buffer RAM. Each RAM's checker reports correctable (single-bit) and uncorrectable (double-bit) error events on single-cycle inputs. Each event sets a sticky status bit that software clears by writing 1 to it. A separate enable register selects which status bits drive a combined interrupt line.

The same status word holds two error-injection request bits for the read FIFO RAM. When either bit goes from 0 to 1, the block emits one single-cycle pulse toward the RAM wrapper, which corrupts the next stored word. Leaving the bit at 1 does not repeat the injection, and neither does writing 1 again. Software reaches the block through a simple register port. Writes take effect at the clock edge, and reads return the addressed word combinationally.

Top module: `eccErrCsr`

## Requirements
- R1: After reset, every status bit, both injection bits and the whole enable register read 0. `irq`, `injSglPulse` and `injDblPulse` are low.
- R2: A 1 on `errEvt[i]` at a clock edge sets status bit 7+i of word 0, and the bit reads back from the next cycle on. The bit order is: bit 7 ECC buffer single, bit 8 ECC buffer double, bit 9 write FIFO single, bit 10 write FIFO double, bit 11 read FIFO single, bit 12 read FIFO double. A set bit stays set until software clears it.
- R3: Writing word 0 with a 1 in status bit position 7..12 clears that bit. A 0 in any of those positions leaves the bit unchanged.
- R4: When an error event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Bit 5 (single-bit injection) and bit 6 (double-bit injection) of word 0 are plain read/write storage and read back the value last written.
- R6: A write that takes an injection bit from 0 to 1 raises the matching pulse output for exactly the one cycle after the write. Writing 1 over a 1, or writing 0, produces no pulse.
- R7: Word 1 holds six enable bits at positions 7..12, one per status bit at the same position. `irq` is high exactly when some status bit and its enable bit are both 1.
- R8: Bits 31..13 and 4..0 of word 0, and every bit of word 1 outside 7..12, read 0 and ignore writes. Any other address reads 0.
- R9: Register reads have no side effects. Reading word 0 leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address (0 status/inject, 1 enable) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed word |
| errEvt | input | 6 | Error event per status source, bit i maps to status bit 7+i |
| irq | output | 1 | Combined enabled-error interrupt |
| injSglPulse | output | 1 | One-cycle single-bit injection request |
| injDblPulse | output | 1 | One-cycle double-bit injection request |

## Verification
The assertions assume that `errEvt` and the bus inputs change only between clock edges. They also assume that a write strobe lasts exactly one cycle, so that the one-shot and clear properties see one write per edge. The bench drives every input on the falling edge and holds each write for a single cycle. It sweeps all 64 status patterns against all 64 enable patterns. It also sets and clears the same bit in the same cycle, so the set-wins rule is exercised inside these assumptions.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned NUM_RAM     = 3;
  localparam int unsigned NUM_SRC     = 2 * NUM_RAM;
  localparam int unsigned STAT_LSB    = 7;
  localparam int unsigned STAT_MSB    = STAT_LSB + NUM_SRC - 1;
  localparam int unsigned INJ_SGL_POS = 5;
  localparam int unsigned INJ_DBL_POS = 6;

  typedef struct packed {
    logic               statWr;
    logic               maskWr;
    logic [NUM_SRC-1:0] clrBits;
    logic [NUM_SRC-1:0] maskVal;
    logic [1:0]         injVal;   // [0] single, [1] double
    logic               rdStat;
    logic               rdMask;
  } csrStrobes_t;
endpackage

// File: rtl/eccCsrCtrl.sv
module eccCsrCtrl
  import ecc_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned MASK_ADDR = 1
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output csrStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] MaskA = ADDR_W'(MASK_ADDR);

  logic hitStat, hitMask;
  logic unusedWdata;

  assign hitStat = (busAddr == StatA);
  assign hitMask = (busAddr == MaskA);
  assign unusedWdata = ^{busWdata[DATA_W-1:STAT_MSB+1], busWdata[INJ_SGL_POS-1:0]};

  always_comb begin
    strb.statWr  = busSel && busWr && hitStat;
    strb.maskWr  = busSel && busWr && hitMask;
    strb.clrBits = strb.statWr ? busWdata[STAT_MSB:STAT_LSB] : '0;
    strb.maskVal = busWdata[STAT_MSB:STAT_LSB];
    strb.injVal  = {busWdata[INJ_DBL_POS], busWdata[INJ_SGL_POS]};
    strb.rdStat  = hitStat;
    strb.rdMask  = hitMask;
  end
endmodule

// File: rtl/eccCsrDp.sv
module eccCsrDp
  import ecc_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  csrStrobes_t        strb,
  input  logic [NUM_SRC-1:0] errEvt,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq,
  output logic               injSglPulse,
  output logic               injDblPulse
);
  logic [NUM_SRC-1:0] statReg, maskReg;
  logic [1:0]         injReg, injPrev, injPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
      maskReg <= '0;
      injReg  <= '0;
      injPrev <= '0;
    end else begin
      statReg <= (statReg & ~strb.clrBits) | errEvt;
      if (strb.maskWr) maskReg <= strb.maskVal;
      if (strb.statWr) injReg  <= strb.injVal;
      injPrev <= injReg;
    end
  end

  assign injPulse    = injReg & ~injPrev;
  assign injSglPulse = injPulse[0];
  assign injDblPulse = injPulse[1];
  assign irq         = |(statReg & maskReg);

  always_comb begin
    busRdata = '0;
    if (strb.rdStat) begin
      busRdata[STAT_MSB:STAT_LSB] = statReg;
      busRdata[INJ_SGL_POS]       = injReg[0];
      busRdata[INJ_DBL_POS]       = injReg[1];
    end else if (strb.rdMask) begin
      busRdata[STAT_MSB:STAT_LSB] = maskReg;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_statChk
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
      errEvt[i] |=> statReg[i]); // R2 R4
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (statReg[i] && !strb.clrBits[i]) |=> statReg[i]); // R2 R3
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrBits[i] && !errEvt[i]) |=> !statReg[i]); // R3
  end

  AST_SGL_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    injSglPulse |=> !injSglPulse); // R6
  AST_DBL_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    injDblPulse |=> !injDblPulse); // R6
  AST_SGL_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    injSglPulse |-> $past(strb.statWr && strb.injVal[0])); // R6
endmodule

// File: rtl/eccErrCsr.sv
module eccErrCsr
  import ecc_csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned MASK_ADDR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] errEvt,
  output logic               irq,
  output logic               injSglPulse,
  output logic               injDblPulse
);
  csrStrobes_t strb;

  eccCsrCtrl #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)) i_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .strb(strb)
  );

  eccCsrDp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .errEvt(errEvt), .busRdata(busRdata),
    .irq(irq), .injSglPulse(injSglPulse), .injDblPulse(injDblPulse)
  );
endmodule

// File: tb/test_eccErrCsr.sv
module test_eccErrCsr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0, busWr = 0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [5:0]  errEvt = '0;
  logic        irq, injSglPulse, injDblPulse;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eccErrCsr i_eccErrCsr (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .errEvt(errEvt), .irq(irq),
    .injSglPulse(injSglPulse), .injDblPulse(injDblPulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; busWdata = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic fireEvt(input logic [5:0] e);
    @(negedge clk); errEvt = e;
    @(negedge clk); errEvt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    busRead(0, rd); check(rd == 0, "R1 word0", rd, 0);
    busRead(1, rd); check(rd == 0, "R1 word1", rd, 0);
    check({irq, injSglPulse, injDblPulse} == 0, "R1 outputs", {irq, injSglPulse, injDblPulse}, 0);

    // R2 single-source mapping, R9 read without side effect
    for (int i = 0; i < 6; i++) begin
      fireEvt(6'(1 << i));
      busRead(0, rd); check(rd == (32'd1 << (7 + i)), "R2 map", rd, 32'd1 << (7 + i));
      @(negedge clk);
      busRead(0, rd); check(rd == (32'd1 << (7 + i)), "R9 read no side effect", rd, 32'd1 << (7 + i));
      busWrite(0, 32'd0);
      busRead(0, rd); check(rd == (32'd1 << (7 + i)), "R3 write 0 keeps", rd, 32'd1 << (7 + i));
      busWrite(0, 32'd1 << (7 + i));
      busRead(0, rd); check(rd == 0, "R3 write 1 clears", rd, 0);
    end

    // R4 set beats clear
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 0; busWdata = 32'h1000; errEvt = 6'h20;
    @(negedge clk);
    busSel = 0; busWr = 0; busWdata = 0; errEvt = 0;
    busRead(0, rd); check(rd == 32'h1000, "R4 set wins", rd, 32'h1000);
    busWrite(0, 32'h1000);

    // R7 exhaustive status x enable sweep
    for (int s = 0; s < 64; s++) begin
      fireEvt(6'(s));
      busRead(0, rd); check(rd == (32'(s) << 7), "R2 pattern", rd, 32'(s) << 7);
      for (int m = 0; m < 64; m++) begin
        busWrite(1, 32'(m) << 7);
        check(irq == ((s & m) != 0), "R7 irq", {31'd0, irq}, {31'd0, (s & m) != 0});
      end
      busWrite(0, 32'(s) << 7);
      busRead(0, rd); check(rd == 0, "R3 clear pattern", rd, 0);
    end
    busWrite(1, 0);

    // R5/R6 injection
    busWrite(0, 32'h20);
    check(injSglPulse && !injDblPulse, "R6 sgl rise", {30'd0, injSglPulse, injDblPulse}, 32'h2);
    @(negedge clk);
    check(!injSglPulse, "R6 sgl one cycle", {31'd0, injSglPulse}, 0);
    busRead(0, rd); check(rd == 32'h20, "R5 sgl readback", rd, 32'h20);
    busWrite(0, 32'h20);
    check(!injSglPulse, "R6 rewrite 1 no pulse", {31'd0, injSglPulse}, 0);
    busWrite(0, 32'h60);
    check(injDblPulse && !injSglPulse, "R6 dbl rise", {30'd0, injSglPulse, injDblPulse}, 32'h1);
    @(negedge clk);
    check(!injDblPulse, "R6 dbl one cycle", {31'd0, injDblPulse}, 0);
    busWrite(0, 32'h00);
    check(!injSglPulse && !injDblPulse, "R6 fall no pulse", {30'd0, injSglPulse, injDblPulse}, 0);
    busRead(0, rd); check(rd == 0, "R5 cleared readback", rd, 0);
    busWrite(0, 32'h60);
    check(injSglPulse && injDblPulse, "R6 both rise", {30'd0, injSglPulse, injDblPulse}, 32'h3);

    // R8 reserved bits and unmapped addresses
    busWrite(0, 32'hFFFF_FFFF);
    busRead(0, rd); check(rd == 32'h60, "R8 word0 reserved", rd, 32'h60);
    busWrite(1, 32'hFFFF_FFFF);
    busRead(1, rd); check(rd == 32'h1F80, "R8 word1 reserved", rd, 32'h1F80);
    busWrite(2, 32'hFFFF_FFFF);
    busRead(2, rd); check(rd == 0, "R8 unmapped", rd, 0);
    busRead(0, rd); check(rd == 32'h60, "R8 unmapped write ignored", rd, 32'h60);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule